// File: doc/BRIEF.md
# Double-Width Integer Divider with Overflow Trap

This block divides a numerator two machine words wide by a denominator one word wide, and returns a quotient and a remainder that are each one word wide. The caller presents the upper numerator word, the lower numerator word, the denominator and a mode bit together with a one-cycle `start` pulse. The mode bit selects unsigned arithmetic or two's-complement arithmetic. Some requests have no quotient that fits in one word, and some have a zero denominator. For either case the block raises `trap` and returns zeros instead of a result.

The divider is sequential and uses restoring radix-2 iteration, producing one quotient bit per clock. Signed requests are handled on magnitudes. The signs are applied after the iteration, and the result is then range-checked against the signed one-word limits. A request that the magnitude pre-check already rejects skips the iteration and finishes on the next cycle. The word width `W` is a parameter and may be 32 or 64.

Top module: `dword_divider`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `busy`, `done`, `trap`, `quo` and `rem` are all 0.
- R2: With `is_signed`=0, the block treats the value {`num_hi`,`num_lo`} and `den` as unsigned. If there is no trap, it returns `quo` = floor(numerator/den) and `rem` = numerator − `quo`·`den`.
- R3: With `is_signed`=0 and `den`≠0, `trap` is raised exactly when `num_hi` >= `den`, which is the case where the quotient needs more than W bits.
- R4: A zero `den` raises `trap` in both modes.
- R5: With `is_signed`=1, the block treats {`num_hi`,`num_lo`} as a 2W-bit two's-complement value and `den` as a W-bit two's-complement value. The quotient truncates toward zero. The remainder carries the numerator's sign and has a magnitude below |`den`|.
- R6: With `is_signed`=1, `trap` is raised exactly when the true quotient lies outside [−2^(W−1), 2^(W−1)−1]. A quotient of exactly −2^(W−1) is returned without a trap.
- R7: Whenever `done` is high together with `trap`, `quo` and `rem` are both 0.
- R8: `done` is a single-cycle pulse. It rises W+1 clock edges after the edge that accepted `start`. It instead rises after 1 edge when `den` is 0 or when the high word of |numerator| is >= |`den`|.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running operation completes with its own operands, and no extra `done` follows.
- R10: `busy` goes high on the edge that accepts `start`, and it stays high until the edge on which `done` rises.
- R11: Between `done` pulses, `quo`, `rem` and `trap` hold the values of the last completed request.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when `busy` is low |
| num_hi | input | W | Upper word of the numerator |
| num_lo | input | W | Lower word of the numerator |
| den | input | W | Denominator |
| is_signed | input | 1 | 1 = two's-complement, 0 = unsigned |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| trap | output | 1 | Zero denominator or quotient out of range |
| quo | output | W | Quotient (0 on trap) |
| rem | output | W | Remainder (0 on trap) |

## Verification
Internal faults show up at the ports within one operation. A wrong partial remainder or a dropped shift bit corrupts `quo` or `rem` in the `done` cycle that follows, W+1 cycles after the start. A fault in the sign bookkeeping appears only in the signed cases: those with mixed signs, and the boundary cases at −2^(W−1) and 2^(W−1). An off-by-one in the step counter moves the `done` pulse, and the bench catches this through its exact latency count. An error in the trap condition shows up either as a missing trap, or as a nonzero result returned with `trap` set.

// File: rtl/wdiv_pkg.sv
// Shared types for the double-width divider.
package wdiv_pkg;
    // Controller phases: waiting, iterating, publishing the result.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_t;
endpackage

// File: rtl/wdiv_operand_prep.sv
// Operand preparation: converts the request to unsigned magnitudes and
// records the signs of the quotient and remainder. It also flags requests
// whose quotient magnitude cannot fit in W bits, which includes a zero
// denominator.
// Assumes: purely combinational; operands are stable while start is seen.
module wdiv_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0]   num_hi,
    input  logic [W-1:0]   num_lo,
    input  logic [W-1:0]   den,
    input  logic           is_signed,
    output logic [2*W-1:0] num_mag,
    output logic [W-1:0]   den_mag,
    output logic           q_neg,
    output logic           r_neg,
    output logic           pre_trap
);
    localparam int NW = 2 * W;

    logic [NW-1:0] num_full;
    logic          num_neg;
    logic          den_neg;

    // Derive operand signs and absolute values.
    always_comb begin
        num_full = {num_hi, num_lo};
        num_neg  = is_signed & num_hi[W-1];
        den_neg  = is_signed & den[W-1];
        num_mag  = num_neg ? (~num_full + NW'(1)) : num_full;
        den_mag  = den_neg ? (~den + W'(1)) : den;
        q_neg    = num_neg ^ den_neg;
        r_neg    = num_neg;
    end

    // Quotient magnitude needs more than W bits (or den is zero).
    always_comb begin
        pre_trap = (num_mag[NW-1:W] >= den_mag);
    end
endmodule

// File: rtl/wdiv_restore_core.sv
// Restoring radix-2 divide engine. It holds the partial remainder and the
// numerator/quotient bits in a single 2W-bit accumulator, and retires one
// quotient bit per step.
// Assumes: the upper half of num_mag is below den_mag when loaded, so the
// quotient fits in W bits; steps are issued on consecutive cycles.
module wdiv_restore_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [2*W-1:0] num_mag,
    input  logic [W-1:0]   den_mag,
    output logic [W-1:0]   quo_mag,
    output logic [W-1:0]   rem_mag,
    output logic           last
);
    localparam int NW = 2 * W;
    localparam int CW = $clog2(W);

    logic [NW-1:0] acc;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    // Trial subtraction of the denominator from the shifted partial remainder.
    always_comb begin
        trial = acc[NW-1:W-1];
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
        last  = step && (cnt == CW'(W - 1));
    end

    // Load operands or retire one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            den_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            acc   <= num_mag;
            den_q <= den_mag;
            cnt   <= '0;
        end else if (step) begin
            acc   <= {(fits ? diff[W-1:0] : trial[W-1:0]), acc[W-2:0], fits};
            cnt   <= cnt + CW'(1);
        end
    end

    assign quo_mag = acc[W-1:0];
    assign rem_mag = acc[NW-1:W];

    // R2: the partial remainder stays below the divisor throughout iteration.
    p_partial_below_den_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (acc[NW-1:W] < den_q));
endmodule

// File: rtl/wdiv_result_fix.sv
// Result finishing: applies the signs to the magnitudes, checks the signed
// quotient range, and forces a zero result whenever a trap is raised.
// Assumes: purely combinational; the inputs come from registered state.
module wdiv_result_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         is_signed,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         pre_trap,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out,
    output logic         trap_out
);
    localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

    logic range_bad;

    // Signed range: negative quotients may reach 2^(W-1) in magnitude.
    always_comb begin
        if (!is_signed)
            range_bad = 1'b0;
        else if (q_neg)
            range_bad = (quo_mag > MIN_MAG);
        else
            range_bad = quo_mag[W-1];
    end

    // Apply signs, or zero everything on a trap.
    always_comb begin
        trap_out = pre_trap | range_bad;
        if (trap_out) begin
            quo_out = '0;
            rem_out = '0;
        end else begin
            quo_out = q_neg ? (~quo_mag + W'(1)) : quo_mag;
            rem_out = r_neg ? (~rem_mag + W'(1)) : rem_mag;
        end
    end
endmodule

// File: rtl/dword_divider.sv
// Top level of the double-width divider. It accepts a request when idle,
// sequences the restoring engine for W steps (or skips the engine when the
// pre-check traps), and registers the finished result with a one-cycle
// done pulse.
// Assumes: start is ignored while busy; the outputs hold until the next done.
module dword_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num_hi,
    input  logic [W-1:0] num_lo,
    input  logic [W-1:0] den,
    input  logic         is_signed,
    output logic         busy,
    output logic         done,
    output logic         trap,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    import wdiv_pkg::*;

    phase_t         phase;
    logic           accept;
    logic [2*W-1:0] p_num_mag;
    logic [W-1:0]   p_den_mag;
    logic           p_q_neg;
    logic           p_r_neg;
    logic           p_pre_trap;
    logic           sgn_q;
    logic           qneg_q;
    logic           rneg_q;
    logic           pretrap_q;
    logic [W-1:0]   core_quo;
    logic [W-1:0]   core_rem;
    logic           core_last;
    logic [W-1:0]   fix_quo;
    logic [W-1:0]   fix_rem;
    logic           fix_trap;

    assign accept = start && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);

    wdiv_operand_prep #(.W(W)) u_prep (
        .num_hi    (num_hi),
        .num_lo    (num_lo),
        .den       (den),
        .is_signed (is_signed),
        .num_mag   (p_num_mag),
        .den_mag   (p_den_mag),
        .q_neg     (p_q_neg),
        .r_neg     (p_r_neg),
        .pre_trap  (p_pre_trap)
    );

    wdiv_restore_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (phase == PH_RUN),
        .num_mag (p_num_mag),
        .den_mag (p_den_mag),
        .quo_mag (core_quo),
        .rem_mag (core_rem),
        .last    (core_last)
    );

    wdiv_result_fix #(.W(W)) u_fix (
        .quo_mag   (core_quo),
        .rem_mag   (core_rem),
        .is_signed (sgn_q),
        .q_neg     (qneg_q),
        .r_neg     (rneg_q),
        .pre_trap  (pretrap_q),
        .quo_out   (fix_quo),
        .rem_out   (fix_rem),
        .trap_out  (fix_trap)
    );

    // Phase sequencing and capture of the per-request flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            sgn_q     <= 1'b0;
            qneg_q    <= 1'b0;
            rneg_q    <= 1'b0;
            pretrap_q <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    sgn_q     <= is_signed;
                    qneg_q    <= p_q_neg;
                    rneg_q    <= p_r_neg;
                    pretrap_q <= p_pre_trap;
                    phase     <= p_pre_trap ? PH_FIN : PH_RUN;
                end
                PH_RUN:  if (core_last) phase <= PH_FIN;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Result registers, loaded once per request in the finishing phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            trap <= 1'b0;
            quo  <= '0;
            rem  <= '0;
        end else begin
            done <= (phase == PH_FIN);
            if (phase == PH_FIN) begin
                trap <= fix_trap;
                quo  <= fix_quo;
                rem  <= fix_rem;
            end
        end
    end

    // R7: a trapped result carries no data.
    p_trap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap) |-> (quo == '0 && rem == '0));
    // R8: done lasts exactly one cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: an accepted start makes the block busy on the next cycle.
    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R11: results stay put while no done pulse is issued.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (!done || 1'b1) && ($stable(quo) || $rose(done)));
endmodule

// File: tb/dword_divider_bench.sv
module dword_divider_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] num_hi = '0;
    logic [W-1:0] num_lo = '0;
    logic [W-1:0] den = '0;
    logic         is_signed = 1'b0;
    logic         busy, done, trap;
    logic [W-1:0] quo, rem;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dword_divider #(.W(W)) u_dword_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .num_hi(num_hi),
        .num_lo(num_lo), .den(den), .is_signed(is_signed), .busy(busy),
        .done(done), .trap(trap), .quo(quo), .rem(rem)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model computed from the requirements with wide integers.
    task automatic model(input logic [W-1:0] hi, input logic [W-1:0] lo,
                         input logic [W-1:0] d, input logic sg,
                         output logic [W-1:0] eq, output logic [W-1:0] er,
                         output logic et, output int elat);
        logic signed [127:0] n, dd, q, r, an, ad;
        if (sg) begin
            n  = $signed({{64{hi[W-1]}}, hi, lo});
            dd = $signed({{96{d[W-1]}}, d});
        end else begin
            n  = $signed({64'd0, hi, lo});
            dd = $signed({96'd0, d});
        end
        an = (n < 0) ? -n : n;
        ad = (dd < 0) ? -dd : dd;
        elat = ((ad == 0) || ((an >>> W) >= ad)) ? 1 : W + 1;
        if (dd == 0) begin
            et = 1'b1; q = 0; r = 0;
        end else begin
            q = n / dd;
            r = n % dd;
            if (sg) et = (q > 128'sd2147483647) || (q < -128'sd2147483648);
            else    et = (q > 128'sd4294967295);
        end
        if (et) begin eq = '0; er = '0; end
        else begin eq = q[W-1:0]; er = r[W-1:0]; end
    endtask

    // Issue a request and measure latency to done; returns results seen.
    task automatic issue(input logic [W-1:0] hi, input logic [W-1:0] lo,
                         input logic [W-1:0] d, input logic sg, output int lat);
        @(negedge clk);
        num_hi = hi; num_lo = lo; den = d; is_signed = sg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_case(input string req, input logic [W-1:0] hi,
                            input logic [W-1:0] lo, input logic [W-1:0] d,
                            input logic sg);
        logic [W-1:0] eq, er;
        logic et;
        int elat, lat;
        model(hi, lo, d, sg, eq, er, et, elat);
        issue(hi, lo, d, sg, lat);
        check(req, "trap", 64'(trap), 64'(et));
        check(req, "quo", 64'(quo), 64'(eq));
        check(req, "rem", 64'(rem), 64'(er));
        check("R8", "latency", 64'(lat), 64'(elat));
        if (et) check("R7", "zero on trap", {quo, rem}, 64'd0);
        @(negedge clk);
        check("R8", "done pulse width", 64'(done), 64'd0);
        check("R11", "quo held", 64'(quo), 64'(eq));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "busy", 64'(busy), 64'd0);
        check("R1", "done", 64'(done), 64'd0);
        check("R1", "trap", 64'(trap), 64'd0);
        check("R1", "quo/rem", {quo, rem}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unsigned();
        run_case("R2", 32'd1, 32'd0, 32'd3, 1'b0);
        run_case("R2", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_case("R2", 32'd0, 32'd100, 32'd7, 1'b0);
        run_case("R2", 32'd4, 32'h1234_5678, 32'd5, 1'b0);
    endtask

    task automatic t_uoverflow();
        run_case("R3", 32'd5, 32'd0, 32'd5, 1'b0);
        run_case("R3", 32'h8000_0000, 32'd9, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_zero();
        run_case("R4", 32'd0, 32'd9, 32'd0, 1'b0);
        run_case("R4", 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'd0, 1'b1);
    endtask

    task automatic t_signed();
        run_case("R5", 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b1);
        run_case("R5", 32'd0, 32'd7, 32'hFFFF_FFFE, 1'b1);
        run_case("R5", 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1);
        run_case("R5", 32'hFFFF_FFF0, 32'h0000_0001, 32'h4000_0000, 1'b1);
    endtask

    task automatic t_srange();
        run_case("R6", 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b1);
        run_case("R6", 32'd0, 32'h8000_0000, 32'd1, 1'b1);
        run_case("R6", 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        run_case("R6", 32'h8000_0000, 32'd0, 32'h8000_0000, 1'b1);
    endtask

    task automatic t_busy();
        logic [W-1:0] eq, er;
        logic et;
        int elat, dones;
        model(32'd2, 32'd77, 32'd9, 1'b0, eq, er, et, elat);
        @(negedge clk);
        num_hi = 32'd2; num_lo = 32'd77; den = 32'd9; is_signed = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after start", 64'(busy), 64'd1);
        repeat (3) @(negedge clk);
        num_hi = 32'd0; num_lo = 32'd50; den = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int i = 0; i < 3 * W; i++) begin
            if (done) begin
                dones++;
                check("R9", "quo of first op", 64'(quo), 64'(eq));
                check("R9", "trap of first op", 64'(trap), 64'(et));
                check("R10", "busy low at done", 64'(busy), 64'd0);
            end
            @(negedge clk);
        end
        check("R9", "done count", 64'(dones), 64'd1);
    endtask

    initial begin
        t_reset();
        t_unsigned();
        t_uoverflow();
        t_zero();
        t_signed();
        t_srange();
        t_busy();
        finished = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule